// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block sits beside a NAND flash data path and observes each data word (8 or 16 bits, set by a parameter) that crosses between the host and the device during a page transfer. It builds a bit-level Hamming code over the main area of the page. The code has two halves: a true-sense parity word and a complement-sense parity word. Each half holds one bit per bit of the word index (row pairs) and one bit per bit of the bit index inside a word (column pairs). A start pulse clears the code and captures the main-area size. After that many words have been counted the code freezes, so later spare-area traffic cannot disturb it.

On a program cycle, the host copies the two parity words into the spare area. On read-back, the block recomputes the code while the page is read. The host then pulses a check strobe with the two stored words. The block forms the syndrome and classifies it into one of four outcomes: clean, a correctable single-bit data error with its word and bit position, an uncorrectable multi-bit error, or a single flipped bit inside the stored code itself. The result stays on the outputs until the next page starts.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset, lock_o is 1, parity_o and nparity_o are zero, and all four error flags and the location outputs are zero. Data is not accumulated until a start pulse arrives.
- R2: A start_i pulse clears both codes, drops lock_o, clears the error flags, and captures page_sel_i as the main-area size (0 = 512, 1 = 1024, 2 = 2048, 3 = 4096 words). A word presented with valid_i in the same cycle as start_i is ignored.
- R3: The code bit layout is parity_o = {row[ROW_W-1:0], col[COL_W-1:0]}, and nparity_o uses the same layout. The parity_o bit for column j is the XOR of every data bit whose bit index has bit j set; the nparity_o bit is the XOR of those whose bit index has bit j clear. The row k bits are formed the same way over the word index. Row bits at or above log2(page size) stay 0 in both words.
- R4: lock_o rises in the cycle after the last main-area word is accepted. While it is high, further valid_i words leave both codes unchanged.
- R5: A change of page_sel_i after the start pulse has no effect on the page in progress.
- R6: One cycle after a chk_i strobe, exactly one of the flags err_none_o, err_corr_o, err_multi_o, err_ecc_o is 1. err_none_o is set when the stored codes equal the computed ones.
- R7: A single flipped data bit at word w, bit b sets err_corr_o, with err_word_o = w and err_bit_o = b.
- R8: Two flipped data bits in the page (in the same word or in different words) set err_multi_o.
- R9: A single flipped bit in either stored code word sets err_ecc_o.
- R10: The flags and the location hold their values until the next start_i, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of page access: clear the code and capture the size |
| page_sel_i | input | 2 | Main-area size select |
| valid_i | input | 1 | A data word is on data_i |
| data_i | input | DATA_W | Data word on the flash bus |
| chk_i | input | 1 | Compare the stored code with the computed one |
| stored_p_i | input | CODE_W | True-sense code read from the spare area |
| stored_n_i | input | CODE_W | Complement-sense code read from the spare area |
| parity_o | output | CODE_W | True-sense computed code |
| nparity_o | output | CODE_W | Complement-sense computed code |
| lock_o | output | 1 | Code is frozen |
| err_none_o | output | 1 | Check result: clean |
| err_corr_o | output | 1 | Check result: correctable; the location outputs are valid |
| err_multi_o | output | 1 | Check result: uncorrectable |
| err_ecc_o | output | 1 | Check result: error in the stored code |
| err_word_o | output | ROW_W | Word index of the flipped bit |
| err_bit_o | output | COL_W | Bit index of the flipped bit |

## Verification
The bench builds the engine with DATA_W = 8, which gives three column pairs and a 15-bit code. It runs pages of every size from 512 to 4096 words. This reaches the last word of a page, word 0 bit 0 (where every true-sense syndrome bit is zero), and the highest row pair, which only 4096-word pages use. The 8-bit width keeps a full 4096-word page short enough to walk many times, and the bench model computes the code bit by bit rather than word by word.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int ROW_W     = 12;  // index bits of the largest page
  localparam int MIN_ROW_W = 9;   // index bits of the smallest page

  typedef struct packed {
    logic none;
    logic corr;
    logic multi;
    logic ecc_fld;
  } ecc_stat_t;
endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int COL_W = $clog2(DATA_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       page_sel_i,
  input  logic             valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ROW_W-1:0] p_row_o,
  output logic [ROW_W-1:0] n_row_o,
  output logic [COL_W-1:0] p_col_o,
  output logic [COL_W-1:0] n_col_o,
  output logic [ROW_W-1:0] row_mask_o,
  output logic             lock_o
);
  logic [ROW_W-1:0] cnt_q, mask_q, mask_d, p_row_q, n_row_q;
  logic [COL_W-1:0] p_col_q, n_col_q, cp, cn;
  logic             lock_q, wpar, take;

  assign mask_d = ROW_W'((1 << (MIN_ROW_W + int'(page_sel_i))) - 1);
  assign wpar   = ^data_i;
  assign take   = valid_i && !lock_q && !start_i;

  // column pair contributions of one word
  for (genvar j = 0; j < COL_W; j++) begin : g_col
    always_comb begin
      cp[j] = 1'b0;
      cn[j] = 1'b0;
      for (int b = 0; b < DATA_W; b++) begin
        if (((b >> j) & 1) == 1) cp[j] = cp[j] ^ data_i[b];
        else                     cn[j] = cn[j] ^ data_i[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mask_q  <= '0;
      lock_q  <= 1'b1;
      p_row_q <= '0;
      n_row_q <= '0;
      p_col_q <= '0;
      n_col_q <= '0;
    end else if (start_i) begin
      cnt_q   <= '0;
      mask_q  <= mask_d;
      lock_q  <= 1'b0;
      p_row_q <= '0;
      n_row_q <= '0;
      p_col_q <= '0;
      n_col_q <= '0;
    end else if (take) begin
      cnt_q   <= cnt_q + 1'b1;
      p_row_q <= p_row_q ^ ({ROW_W{wpar}} & cnt_q & mask_q);
      n_row_q <= n_row_q ^ ({ROW_W{wpar}} & ~cnt_q & mask_q);
      p_col_q <= p_col_q ^ cp;
      n_col_q <= n_col_q ^ cn;
      if (cnt_q == mask_q) lock_q <= 1'b1;
    end
  end

  assign p_row_o    = p_row_q;
  assign n_row_o    = n_row_q;
  assign p_col_o    = p_col_q;
  assign n_col_o    = n_col_q;
  assign row_mask_o = mask_q;
  assign lock_o     = lock_q;
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int COL_W  = $clog2(DATA_W),
  localparam int CODE_W = ROW_W + COL_W,
  localparam int CNT_W  = $clog2(2 * CODE_W + 1)
) (
  input  logic [CODE_W-1:0] calc_p_i,
  input  logic [CODE_W-1:0] calc_n_i,
  input  logic [CODE_W-1:0] stored_p_i,
  input  logic [CODE_W-1:0] stored_n_i,
  input  logic [ROW_W-1:0]  row_mask_i,
  output ecc_stat_t         stat_o,
  output logic [ROW_W-1:0]  word_o,
  output logic [COL_W-1:0]  bit_o
);
  logic [CODE_W-1:0] mask, syn_p, syn_n;
  logic [CNT_W-1:0]  ones;
  logic              zero, pairs_ok;

  assign mask  = {row_mask_i, {COL_W{1'b1}}};
  assign syn_p = (calc_p_i ^ stored_p_i) & mask;
  assign syn_n = (calc_n_i ^ stored_n_i) & mask;

  always_comb begin
    ones = '0;
    for (int i = 0; i < CODE_W; i++) begin
      ones = ones + CNT_W'(syn_p[i]) + CNT_W'(syn_n[i]);
    end
  end

  assign zero     = (ones == '0);
  assign pairs_ok = ((syn_p ^ syn_n) == mask);

  always_comb begin
    stat_o         = '0;
    stat_o.none    = zero;
    stat_o.ecc_fld = (ones == CNT_W'(1));
    stat_o.corr    = pairs_ok;
    stat_o.multi   = !zero && !pairs_ok && (ones != CNT_W'(1));
  end

  assign word_o = pairs_ok ? syn_p[CODE_W-1:COL_W] : '0;
  assign bit_o  = pairs_ok ? syn_p[COL_W-1:0]      : '0;
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int COL_W  = $clog2(DATA_W),
  localparam int CODE_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        page_sel_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              chk_i,
  input  logic [CODE_W-1:0] stored_p_i,
  input  logic [CODE_W-1:0] stored_n_i,
  output logic [CODE_W-1:0] parity_o,
  output logic [CODE_W-1:0] nparity_o,
  output logic              lock_o,
  output logic              err_none_o,
  output logic              err_corr_o,
  output logic              err_multi_o,
  output logic              err_ecc_o,
  output logic [ROW_W-1:0]  err_word_o,
  output logic [COL_W-1:0]  err_bit_o
);
  logic [ROW_W-1:0] p_row, n_row, row_mask, word_d, word_q;
  logic [COL_W-1:0] p_col, n_col, bit_d, bit_q;
  ecc_stat_t        stat_d, stat_q;

  ecc_accum #(.DATA_W(DATA_W)) i_accum (
    .clk_i, .rst_ni, .start_i, .page_sel_i, .valid_i, .data_i,
    .p_row_o(p_row), .n_row_o(n_row), .p_col_o(p_col), .n_col_o(n_col),
    .row_mask_o(row_mask), .lock_o
  );

  assign parity_o  = {p_row, p_col};
  assign nparity_o = {n_row, n_col};

  ecc_classify #(.DATA_W(DATA_W)) i_classify (
    .calc_p_i(parity_o), .calc_n_i(nparity_o),
    .stored_p_i, .stored_n_i, .row_mask_i(row_mask),
    .stat_o(stat_d), .word_o(word_d), .bit_o(bit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      word_q <= '0;
      bit_q  <= '0;
    end else if (start_i) begin
      stat_q <= '0;
      word_q <= '0;
      bit_q  <= '0;
    end else if (chk_i) begin
      stat_q <= stat_d;
      word_q <= word_d;
      bit_q  <= bit_d;
    end
  end

  assign err_none_o  = stat_q.none;
  assign err_corr_o  = stat_q.corr;
  assign err_multi_o = stat_q.multi;
  assign err_ecc_o   = stat_q.ecc_fld;
  assign err_word_o  = word_q;
  assign err_bit_o   = bit_q;
endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int COL_W  = $clog2(DATA_W),
  localparam int CODE_W = ROW_W + COL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              valid_i,
  input logic              chk_i,
  input logic [CODE_W-1:0] parity_o,
  input logic [CODE_W-1:0] nparity_o,
  input logic              lock_o,
  input logic              err_none_o,
  input logic              err_corr_o,
  input logic              err_multi_o,
  input logic              err_ecc_o
);
  logic [3:0] flags;
  assign flags = {err_none_o, err_corr_o, err_multi_o, err_ecc_o};

  // R2
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !lock_o && (flags == 4'b0));

  // R4
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !start_i) |=> $stable(parity_o) && $stable(nparity_o));

  // R4
  lock_after_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(valid_i));

  // R6
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && !start_i) |=> $onehot(flags));

  // R6
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags));

  // R10
  flags_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_i && !start_i) |=> $stable(flags));
endmodule

bind nand_ecc_engine nand_ecc_chk #(.DATA_W(DATA_W)) i_nand_ecc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i),
  .chk_i(chk_i), .parity_o(parity_o), .nparity_o(nparity_o), .lock_o(lock_o),
  .err_none_o(err_none_o), .err_corr_o(err_corr_o),
  .err_multi_o(err_multi_o), .err_ecc_o(err_ecc_o)
);

// File: tb/test_nand_ecc_engine.sv
module test_nand_ecc_engine;
  localparam int DATA_W = 8;
  localparam int COL_W  = 3;
  localparam int ROW_W  = 12;
  localparam int CODE_W = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, valid_i = 1'b0, chk_i = 1'b0;
  logic [1:0] page_sel_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic [CODE_W-1:0] stored_p_i = '0, stored_n_i = '0;
  logic [CODE_W-1:0] parity_o, nparity_o;
  logic lock_o, err_none_o, err_corr_o, err_multi_o, err_ecc_o;
  logic [ROW_W-1:0] err_word_o;
  logic [COL_W-1:0] err_bit_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nand_ecc_engine #(.DATA_W(DATA_W)) i_nand_ecc_engine (
    .clk_i(clk), .rst_ni, .start_i, .page_sel_i, .valid_i, .data_i, .chk_i,
    .stored_p_i, .stored_n_i, .parity_o, .nparity_o, .lock_o,
    .err_none_o, .err_corr_o, .err_multi_o, .err_ecc_o, .err_word_o, .err_bit_o
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [7:0]  seed;
    logic [1:0]  kind;  // 0 clean, 1 one bit, 2 two bits, 3 stored-code bit
    logic [11:0] w1;
    logic [2:0]  b1;
    logic [11:0] w2;
    logic [2:0]  b2;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 8'h3C, 2'd0, 12'd0,    3'd0, 12'd0,   3'd0},
    '{2'd0, 8'h5A, 2'd1, 12'd300,  3'd5, 12'd0,   3'd0},
    '{2'd1, 8'h11, 2'd1, 12'd1023, 3'd7, 12'd0,   3'd0},
    '{2'd1, 8'h77, 2'd2, 12'd4,    3'd0, 12'd900, 3'd0},
    '{2'd2, 8'h99, 2'd3, 12'd7,    3'd0, 12'd0,   3'd0},
    '{2'd3, 8'hE1, 2'd1, 12'd0,    3'd0, 12'd0,   3'd0},
    '{2'd0, 8'h02, 2'd2, 12'd10,   3'd1, 12'd10,  3'd6},
    '{2'd3, 8'h40, 2'd3, 12'd14,   3'd1, 12'd0,   3'd0}
  };

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((i * 37 + seed * 11) ^ (i >> 2));
  endfunction

  // bit-by-bit reference code: {p, n}
  function automatic logic [2*CODE_W-1:0] model(int sel, int seed, int nfl,
                                                 int w1, int b1, int w2, int b2);
    logic [CODE_W-1:0] p = '0, n = '0;
    logic [7:0] d;
    int rb = 9 + sel;
    for (int w = 0; w < (1 << rb); w++) begin
      d = pat(seed, w);
      if (nfl >= 1 && w == w1) d[b1] = ~d[b1];
      if (nfl >= 2 && w == w2) d[b2] = ~d[b2];
      for (int b = 0; b < 8; b++) begin
        if (d[b]) begin
          for (int j = 0; j < COL_W; j++)
            if (((b >> j) & 1) == 1) p[j] = ~p[j]; else n[j] = ~n[j];
          for (int k = 0; k < rb; k++)
            if (((w >> k) & 1) == 1) p[COL_W+k] = ~p[COL_W+k];
            else n[COL_W+k] = ~n[COL_W+k];
        end
      end
    end
    return {p, n};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_page(int sel, bit junk);
    @(negedge clk);
    start_i = 1'b1; page_sel_i = 2'(sel); valid_i = junk; data_i = 8'hFF;
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0;
  endtask

  task automatic stream(int seed, int first, int count);
    for (int i = first; i < first + count; i++) begin
      valid_i = 1'b1; data_i = pat(seed, i);
      @(negedge clk);
    end
    valid_i = 1'b0;
  endtask

  task automatic do_check(logic [CODE_W-1:0] sp, logic [CODE_W-1:0] sn);
    stored_p_i = sp; stored_n_i = sn; chk_i = 1'b1;
    @(negedge clk);
    chk_i = 1'b0;
  endtask

  function automatic logic [3:0] flags();
    return {err_none_o, err_corr_o, err_multi_o, err_ecc_o};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2*CODE_W-1:0] clean, bad;
    logic [CODE_W-1:0] sp, sn;
    logic [3:0] exp_f;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lock", 64'(lock_o), 64'd1);
    check("R1 codes", 64'({parity_o, nparity_o}), 64'd0);
    check("R1 flags", 64'({flags(), err_word_o, err_bit_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 no accumulation before a start pulse
    stream(5, 0, 4);
    check("R1 idle codes", 64'({parity_o, nparity_o}), 64'd0);

    foreach (VECS[v]) begin
      start_page(VECS[v].sel, 1'b0);
      stream(VECS[v].seed, 0, 1 << (9 + VECS[v].sel));
      clean = model(VECS[v].sel, VECS[v].seed, 0, 0, 0, 0, 0);
      check("R3 code", 64'({parity_o, nparity_o}), 64'(clean));
      check("R4 lock", 64'(lock_o), 64'd1);
      stream(VECS[v].seed + 1, 0, 16);  // spare-area traffic
      check("R4 frozen", 64'({parity_o, nparity_o}), 64'(clean));
      case (VECS[v].kind)
        2'd0: begin bad = clean; exp_f = 4'b1000; end
        2'd1: begin
          bad = model(VECS[v].sel, VECS[v].seed, 1, VECS[v].w1, VECS[v].b1, 0, 0);
          exp_f = 4'b0100;
        end
        2'd2: begin
          bad = model(VECS[v].sel, VECS[v].seed, 2, VECS[v].w1, VECS[v].b1,
                      VECS[v].w2, VECS[v].b2);
          exp_f = 4'b0010;
        end
        default: begin
          bad = clean;
          if (VECS[v].b1[0]) bad[VECS[v].w1] = ~bad[VECS[v].w1];
          else bad[CODE_W + VECS[v].w1] = ~bad[CODE_W + VECS[v].w1];
          exp_f = 4'b0001;
        end
      endcase
      {sp, sn} = bad;
      do_check(sp, sn);
      check("R6 R7 R8 R9 flags", 64'(flags()), 64'(exp_f));
      if (VECS[v].kind == 2'd1)
        check("R7 location", 64'({err_word_o, err_bit_o}),
              64'({VECS[v].w1, VECS[v].b1}));
    end

    // R10 result held, then cleared by start
    repeat (5) @(negedge clk);
    check("R10 held", 64'(flags()), 64'b0001);
    // R2 start clears; word in the start cycle is ignored
    start_page(0, 1'b1);
    check("R10 cleared", 64'(flags()), 64'd0);
    check("R2 unlock", 64'(lock_o), 64'd0);
    // R5 size select changed mid page
    page_sel_i = 2'd3;
    stream(33, 0, 511);
    check("R4 not yet", 64'(lock_o), 64'd0);
    stream(33, 511, 1);
    check("R5 lock at 512", 64'(lock_o), 64'd1);
    clean = model(0, 33, 0, 0, 0, 0, 0);
    check("R2 R5 code", 64'({parity_o, nparity_o}), 64'(clean));
    check("R3 unused rows", 64'({parity_o[14:12], nparity_o[14:12]}), 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule